// File: doc/BRIEF.md
# Dual-Cell Boundary Scan Register with Signature, Pattern and Count Modes

This block is the test-side boundary logic that wraps a bidirectional bus transceiver. Every bit position carries two scan cells, one watching and driving the A bus and one watching and driving the B bus. Test data can therefore be observed at, or forced onto, either side independently. The block takes an instruction that has already been decoded to a 3-bit code, plus capture, shift, update and run-idle strobes from an external test access port controller. All of its state is clocked by the test clock.

The A-side cells form the low half of a 2W-bit chain and the B-side cells form the high half. Bit 0 is nearest the serial output. The same chain has three more jobs, chosen by the instruction. It can be a multiple-input signature register that compresses the A-bus inputs. It can be a pseudo-random pattern source that drives the B bus. It can also pair the signature on the A half with a binary count on the B half, which is useful for walking memory addresses. Under the functional and sample codes the transceiver's own outputs pass through untouched. Under every other code the boundary controls the pins.

Top module: `bscan_dual_cell`

## Requirements
- R1: After reset, the chain and the update latches are all zero. With code 2 selected and no update yet, both output buses read zero and tdo reads 0.
- R2: With op_code 0 (functional) or 1 (sample), a_out equals core_a and b_out equals core_b, whatever the scan strobes do.
- R3: A test-clock edge with cap_en high and op_code other than 3 loads chain bits [W-1:0] from a_pin and bits [2W-1:W] from b_pin.
- R4: On an edge with shf_en high, the chain moves one place toward tdo. tdo always shows chain bit 0, and tdi enters bit 2W-1. When shf_en and cap_en are both high, the shift takes effect and the capture does not.
- R5: An edge with upd_en high copies the whole chain into the update latches. The latches change on no other event.
- R6: For op_code 2 through 7, a_out equals update latch bits [W-1:0]. For codes 2, 3, 4 and 7, b_out equals update latch bits [2W-1:W].
- R7: With op_code 3 (self-check), a capture loads the chain from the update latches instead of the pins.
- R8: A run step is an edge with run_en high while shf_en and cap_en are both low. With op_code 4 or 6, each run step sets the A half to step(A) XOR a_pin. Here step(s) shifts s right by one and then XORs in POLY when the old bit 0 was 1. With op_code 4 the B half holds.
- R9: With op_code 5 (pattern), each run step sets the B half to step(B) and the A half holds. b_out follows the B half of the chain directly.
- R10: With op_code 6 (signature plus count), each run step increments the B half by one, modulo 2^W. b_out follows the B half of the chain directly.
- R11: With the default POLY and a nonzero seed, pattern mode first returns to its seed after exactly 2^W-1 run steps.
- R12: Run steps under op_code 0 to 3 leave the chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test logic reset |
| op_code | input | 3 | Decoded instruction: 0 functional, 1 sample, 2 drive, 3 self-check, 4 signature, 5 pattern, 6 signature+count, 7 behaves as 2 |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| run_en | input | 1 | Controller is in run-test/idle |
| tdi | input | 1 | Serial scan input |
| a_pin | input | W | Values observed on the A bus pins |
| b_pin | input | W | Values observed on the B bus pins |
| core_a | input | W | Transceiver's functional drive toward the A bus |
| core_b | input | W | Transceiver's functional drive toward the B bus |
| a_out | output | W | Value driven to the A bus pins |
| b_out | output | W | Value driven to the B bus pins |
| tdo | output | 1 | Serial scan output |

## Verification
The bench builds the block with W = 8 and POLY = 8'hB8, which gives a 16-bit chain. With these values the full pattern cycle of 255 steps can be walked and checked. The count half can also be carried across its wrap from 8'hFF to 8'h00 within a few cycles. The narrow width keeps every shift-in and shift-out to 16 edges. This leaves room for a table of capture/drive vectors and for directed tests of the priority between shift and capture, self-check loopback, and signature compression under changing pins.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
  typedef enum logic [2:0] {
    OP_FUNC    = 3'd0,
    OP_SNAP    = 3'd1,
    OP_DRIVE   = 3'd2,
    OP_LOOPCHK = 3'd3,
    OP_SIG     = 3'd4,
    OP_GEN     = 3'd5,
    OP_SIGCNT  = 3'd6,
    OP_SPARE   = 3'd7
  } bs_op_e;

  // True when the boundary, not the transceiver, owns the pins.
  function automatic logic is_test_op(input bs_op_e op);
    return !(op == OP_FUNC || op == OP_SNAP);
  endfunction

  // True when the B pins are fed live from the chain's upper half.
  function automatic logic b_from_chain(input bs_op_e op);
    return (op == OP_GEN || op == OP_SIGCNT);
  endfunction
endpackage

// File: rtl/bscan_update_bank.sv
`timescale 1ns/1ps
module bscan_update_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= 1'b0;
      else if (load) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 'hB8,
  localparam int          N    = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bs_op_e       op,
  input  logic         cap,
  input  logic         shf,
  input  logic         run,
  input  logic         tdi,
  input  logic [W-1:0] a_pin,
  input  logic [W-1:0] b_pin,
  input  logic [N-1:0] upd_q,
  output logic [N-1:0] chain_q,
  output logic         run_step
);
  // Right-shifting Galois step; maximal length for a primitive POLY.
  function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY : '0);
  endfunction

  function automatic logic [W-1:0] misr_step(input logic [W-1:0] s,
                                             input logic [W-1:0] d);
    return lfsr_step(s) ^ d;
  endfunction

  function automatic logic [W-1:0] count_step(input logic [W-1:0] s);
    return s + W'(1);
  endfunction

  logic [W-1:0] half_a, half_b;
  logic [N-1:0] chain_d;

  assign half_a   = chain_q[W-1:0];
  assign half_b   = chain_q[N-1:W];
  assign run_step = run && !shf && !cap;

  always_comb begin
    chain_d = chain_q;
    if (shf) begin
      chain_d = {tdi, chain_q[N-1:1]};
    end else if (cap) begin
      chain_d = (op == OP_LOOPCHK) ? upd_q : {b_pin, a_pin};
    end else if (run) begin
      unique case (op)
        OP_SIG:    chain_d = {half_b, misr_step(half_a, a_pin)};
        OP_GEN:    chain_d = {lfsr_step(half_b), half_a};
        OP_SIGCNT: chain_d = {count_step(half_b), misr_step(half_a, a_pin)};
        default:   chain_d = chain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/bscan_pin_mux.sv
`timescale 1ns/1ps
module bscan_pin_mux
  import bscan_pkg::*;
#(
  parameter int  W = 8,
  localparam int N = 2 * W
) (
  input  bs_op_e       op,
  input  logic [W-1:0] core_a,
  input  logic [W-1:0] core_b,
  input  logic [N-1:0] upd_q,
  input  logic [W-1:0] chain_b,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out
);
  always_comb begin
    if (!is_test_op(op)) begin
      a_out = core_a;
      b_out = core_b;
    end else begin
      a_out = upd_q[W-1:0];
      b_out = b_from_chain(op) ? chain_b : upd_q[N-1:W];
    end
  end
endmodule

// File: rtl/bscan_dual_cell.sv
`timescale 1ns/1ps
module bscan_dual_cell
  import bscan_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 'hB8
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic [2:0]   op_code,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic         upd_en,
  input  logic         run_en,
  input  logic         tdi,
  input  logic [W-1:0] a_pin,
  input  logic [W-1:0] b_pin,
  input  logic [W-1:0] core_a,
  input  logic [W-1:0] core_b,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         tdo
);
  localparam int N = 2 * W;

  bs_op_e       op;
  logic [N-1:0] chain_q;
  logic [N-1:0] upd_q;
  logic         run_step;

  assign op  = bs_op_e'(op_code);
  assign tdo = chain_q[0];

  bscan_chain #(.W(W), .POLY(POLY)) u_chain (
    .clk      (tck),
    .rst_n    (rst_n),
    .op       (op),
    .cap      (cap_en),
    .shf      (shf_en),
    .run      (run_en),
    .tdi      (tdi),
    .a_pin    (a_pin),
    .b_pin    (b_pin),
    .upd_q    (upd_q),
    .chain_q  (chain_q),
    .run_step (run_step)
  );

  bscan_update_bank #(.N(N)) u_upd (
    .clk   (tck),
    .rst_n (rst_n),
    .load  (upd_en),
    .d     (chain_q),
    .q     (upd_q)
  );

  bscan_pin_mux #(.W(W)) u_mux (
    .op      (op),
    .core_a  (core_a),
    .core_b  (core_b),
    .upd_q   (upd_q),
    .chain_b (chain_q[N-1:W]),
    .a_out   (a_out),
    .b_out   (b_out)
  );
endmodule

// File: rtl/bscan_dual_cell_sva.sv
`timescale 1ns/1ps
module bscan_dual_cell_sva #(
  parameter int  W = 8,
  localparam int N = 2 * W
) (
  input logic         tck,
  input logic         rst_n,
  input logic [2:0]   op_code,
  input logic         shf_en,
  input logic         upd_en,
  input logic         tdi,
  input logic [W-1:0] core_a,
  input logic [W-1:0] core_b,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [N-1:0] chain_q,
  input logic [N-1:0] upd_q,
  input logic         run_step
);
  a_r2_func_pass: assert property (@(posedge tck) disable iff (!rst_n)
    (op_code <= 3'd1) |-> (a_out == core_a && b_out == core_b));

  a_r4_shift_move: assert property (@(posedge tck) disable iff (!rst_n)
    shf_en |=> chain_q == {$past(tdi), $past(chain_q[N-1:1])});

  a_r5_upd_load: assert property (@(posedge tck) disable iff (!rst_n)
    upd_en |=> upd_q == $past(chain_q));

  a_r5_upd_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q));

  a_r6_drive_pins: assert property (@(posedge tck) disable iff (!rst_n)
    (op_code == 3'd2) |-> (a_out == upd_q[W-1:0] && b_out == upd_q[N-1:W]));

  a_r9_gen_live: assert property (@(posedge tck) disable iff (!rst_n)
    (op_code == 3'd5) |-> (b_out == chain_q[N-1:W] && a_out == upd_q[W-1:0]));

  a_r10_count_step: assert property (@(posedge tck) disable iff (!rst_n)
    (run_step && op_code == 3'd6) |=>
      chain_q[N-1:W] == W'($past(chain_q[N-1:W]) + 1'b1));

  a_r12_idle_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (run_step && op_code <= 3'd3) |=> $stable(chain_q));
endmodule

bind bscan_dual_cell bscan_dual_cell_sva #(.W(W)) u_sva (
  .tck      (tck),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .shf_en   (shf_en),
  .upd_en   (upd_en),
  .tdi      (tdi),
  .core_a   (core_a),
  .core_b   (core_b),
  .a_out    (a_out),
  .b_out    (b_out),
  .chain_q  (chain_q),
  .upd_q    (upd_q),
  .run_step (run_step)
);

// File: tb/bscan_dual_cell_tb.sv
`timescale 1ns/1ps
module bscan_dual_cell_tb;
  localparam int         W    = 8;
  localparam int         N    = 2 * W;
  localparam logic [7:0] POLY = 8'hB8;

  logic         tck = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_code = 3'd0;
  logic         cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, run_en = 1'b0;
  logic         tdi = 1'b0;
  logic [W-1:0] a_pin = '0, b_pin = '0, core_a = '0, core_b = '0;
  logic [W-1:0] a_out, b_out;
  logic         tdo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 tck = ~tck;

  bscan_dual_cell #(.W(W), .POLY(POLY)) u_dut (
    .tck(tck), .rst_n(rst_n), .op_code(op_code), .cap_en(cap_en),
    .shf_en(shf_en), .upd_en(upd_en), .run_en(run_en), .tdi(tdi),
    .a_pin(a_pin), .b_pin(b_pin), .core_a(core_a), .core_b(core_b),
    .a_out(a_out), .b_out(b_out), .tdo(tdo)
  );

  // Each entry: {a_pin, b_pin, pattern to drive {B half, A half}}
  localparam logic [31:0] VEC [4] = '{
    32'h12_34_A5C3, 32'hFF_00_0F0F, 32'h00_FF_8001, 32'h5A_A5_7E18
  };

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Independent bitwise restatement of the next-state rule in R8/R9.
  function automatic logic [7:0] model_step(input logic [7:0] s);
    logic [8:0] ext;
    logic [7:0] r;
    ext = {1'b0, s};
    for (int i = 0; i < 8; i++) r[i] = ext[i+1] ^ (s[0] & POLY[i]);
    return r;
  endfunction

  task automatic shift_word(input logic [N-1:0] din, output logic [N-1:0] dout);
    for (int k = 0; k < N; k++) begin
      dout[k] = tdo;
      tdi = din[k];
      shf_en = 1'b1;
      tick();
    end
    shf_en = 1'b0;
  endtask

  task automatic read_chain(output logic [N-1:0] v);
    for (int k = 0; k < N; k++) begin
      v[k] = tdo;
      tdi = tdo;
      shf_en = 1'b1;
      tick();
    end
    shf_en = 1'b0;
  endtask

  task automatic pulse_update();
    upd_en = 1'b1; tick(); upd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] got, prev, last;
    logic [7:0] mod_a, mod_b, seed;
    int ret_at;
    bit seq_ok;

    core_a = 8'hA5; core_b = 8'h3C;
    #12 rst_n = 1'b1;
    tick();

    // R1: reset state
    op_code = 3'd2; #1;
    chk("R1 a_out zero", a_out, 0);
    chk("R1 b_out zero", b_out, 0);
    chk("R1 tdo zero", tdo, 0);
    // R2: functional and sample codes pass the core through, even while shifting
    op_code = 3'd0; shf_en = 1'b1; tdi = 1'b1; tick(); shf_en = 1'b0; tdi = 1'b0;
    chk("R2 func a", a_out, 8'hA5);
    chk("R2 func b", b_out, 8'h3C);
    op_code = 3'd1; #1;
    chk("R2 sample a+b", {a_out, b_out}, 16'hA53C);

    // Vector table: capture (R3), shift (R4), update hold/load (R5), drive (R6)
    op_code = 3'd2;
    read_chain(got);
    prev = '0;
    for (int v = 0; v < 4; v++) begin
      a_pin = VEC[v][31:24]; b_pin = VEC[v][23:16];
      cap_en = 1'b1; tick(); cap_en = 1'b0;
      shift_word(VEC[v][15:0], got);
      chk("R3 captured pins", got, {VEC[v][23:16], VEC[v][31:24]});
      chk("R5 latches hold before update", {b_out, a_out}, prev);
      pulse_update();
      chk("R6 drive from latches", {b_out, a_out}, VEC[v][15:0]);
      prev = VEC[v][15:0];
    end
    last = prev;

    // R4: shift wins over capture; tdi enters the top bit
    a_pin = 8'hFF; b_pin = 8'hFF; tdi = 1'b1;
    shf_en = 1'b1; cap_en = 1'b1; tick(); shf_en = 1'b0; cap_en = 1'b0;
    read_chain(got);
    chk("R4 shift priority", got, {1'b1, last[N-1:1]});

    // R7: self-check capture loops the latches back
    op_code = 3'd3; a_pin = 8'h00; b_pin = 8'h00;
    cap_en = 1'b1; tick(); cap_en = 1'b0;
    read_chain(got);
    chk("R7 loopback", got, last);

    // R12: run steps under code 1 and 3 leave the chain alone
    op_code = 3'd1; run_en = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    run_en = 1'b0;
    read_chain(got);
    chk("R12 idle code 1", got, last);
    op_code = 3'd3; run_en = 1'b1; tick(); tick(); run_en = 1'b0;
    read_chain(got);
    chk("R12 idle code 3", got, last);

    // R8: signature on A half, B half holds
    op_code = 3'd4;
    shift_word(16'hC381, got);
    mod_a = 8'h81;
    run_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      a_pin = 8'(8'h11 * k);
      mod_a = model_step(mod_a) ^ a_pin;
      tick();
    end
    run_en = 1'b0;
    read_chain(got);
    chk("R8 signature A half", got[7:0], mod_a);
    chk("R8 B half holds", got[15:8], 8'hC3);

    // R9/R11: pattern generation from seed 01, A pins from latch 3C
    op_code = 3'd2;
    shift_word(16'h013C, got);
    pulse_update();
    op_code = 3'd5; #1;
    seed = 8'h01;
    chk("R9 b_out shows chain seed", b_out, seed);
    mod_b = seed; ret_at = 0; seq_ok = 1'b1;
    run_en = 1'b1;
    for (int k = 1; k <= 255; k++) begin
      tick();
      mod_b = model_step(mod_b);
      if (b_out !== mod_b || a_out !== 8'h3C) seq_ok = 1'b0;
      if (ret_at == 0 && b_out == seed) ret_at = k;
    end
    run_en = 1'b0;
    chk("R9 pattern sequence", seq_ok, 1);
    chk("R11 period", ret_at, 255);

    // R10: count wraps on B, signature continues on A
    op_code = 3'd2;
    shift_word(16'hFE00, got);
    op_code = 3'd6; a_pin = 8'h5A; mod_a = 8'h00;
    run_en = 1'b1;
    tick(); mod_a = model_step(mod_a) ^ 8'h5A;
    chk("R10 count FF", b_out, 8'hFF);
    tick(); mod_a = model_step(mod_a) ^ 8'h5A;
    chk("R10 count wrap 00", b_out, 8'h00);
    tick(); mod_a = model_step(mod_a) ^ 8'h5A;
    chk("R10 count 01", b_out, 8'h01);
    run_en = 1'b0;
    read_chain(got);
    chk("R8 signature under code 6", got, {8'h01, mod_a});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule